// File: doc/BRIEF.md
# Level-to-Pulse Converter

This block is a synchronous rising-edge detector. Each time the level input `level_in` goes from low to high, it emits a pulse that is exactly one clock period wide. It has no other outputs that depend on the input.

The block holds two independent implementations side by side, so their timing can be compared on the same stimulus. The first is a three-state Moore machine. Its pulse is decoded from the state register alone, so it appears one clock after the rising edge is sampled. The second is a two-state Mealy machine. It stores the previous sample of the input and combines it with the live input, so its pulse appears in the same cycle as the rise. Both state vectors are brought out so they can be observed.

Reset is synchronous and active low. Input synchronisation, debouncing and display decoding belong to the logic around the block.

Top module: `lvl_pulse_top`

## Requirements
- R1: At every clock edge where `rst_n` is 0, the Moore state becomes 2'b00 and the Mealy state becomes 0. While `rst_n` is 0, `mealy_pulse` is 0 whatever the value of `level_in`.
- R2: The Moore state follows the encoding 2'b00 = waiting for a rise, 2'b01 = edge seen, 2'b11 = held high.
  - With `level_in` = 1, 00 goes to 01, 01 goes to 11, and 11 stays at 11.
  - With `level_in` = 0, every state goes to 00.
  - The unused code 2'b10 goes to 00 on the next edge.
- R3: `moore_pulse` is 1 exactly when the Moore state is 2'b01.
- R4: After each clock edge out of reset, `mealy_state` equals the value `level_in` had at that edge.
- R5: `mealy_pulse` equals `level_in` AND NOT `mealy_state`, combinationally, in the same cycle that `level_in` rises.
- R6: `moore_pulse` in a cycle equals `mealy_pulse` of the cycle before it, so the Moore pulse is always one clock later than the Mealy pulse.
- R7: When `level_in` is held high for many cycles, each machine produces exactly one single-cycle pulse.
- R8: When `level_in` drops for only one cycle and rises again, each machine produces a new pulse for the second rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| level_in | input | 1 | Level input, already synchronous to `clk` |
| moore_pulse | output | 1 | Registered one-cycle pulse from the Moore machine |
| mealy_pulse | output | 1 | Combinational one-cycle pulse from the Mealy machine |
| moore_state | output | 2 | Moore state code (00, 01, 11) |
| mealy_state | output | 1 | Mealy state (the previous sample of `level_in`) |

## Verification
The bench drives the input at the falling edge. It checks each output, every cycle, against a model that keeps the last two samples of the input. This would expose three kinds of error:
- a Moore decode that also pulses in the held state, which gives a pulse two or more cycles wide under a long high level;
- a Mealy pulse that is registered instead of combinational, which arrives a cycle late and matches the Moore pulse;
- next-state logic that stays in the held state after a fall, which misses the second pulse of a one-cycle low gap.

The bench also asserts reset while the input is high. A Mealy pulse that was not gated by reset would show up as a 1 during reset.

// File: rtl/lvl_pulse_pkg.sv
// Package: lvl_pulse_pkg
// Shared state codes for the level-to-pulse machines.
// Assumes the Moore codes are fixed because the pulse and the next-state
// equations are written on their individual bits.
package lvl_pulse_pkg;
    localparam int MOORE_W = 2;
    localparam logic [MOORE_W-1:0] MO_WAIT_RISE = 2'b00;
    localparam logic [MOORE_W-1:0] MO_EDGE_SEEN = 2'b01;
    localparam logic [MOORE_W-1:0] MO_HELD_HIGH = 2'b11;
    localparam logic [MOORE_W-1:0] MO_UNUSED    = 2'b10;
    localparam logic               ME_WAS_LOW   = 1'b0;
    localparam logic               ME_WAS_HIGH  = 1'b1;
endpackage

// File: rtl/lvl_pulse_moore.sv
// Module: lvl_pulse_moore
// Three-state Moore rising-edge detector. The pulse is decoded from the
// state register only, so it lags the sampled rise by one clock.
// Assumes level_i is synchronous to clk. Reset is synchronous, active low.
module lvl_pulse_moore
    import lvl_pulse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_i,
    output logic               pulse_o,
    output logic [MOORE_W-1:0] state_o
);
    logic [MOORE_W-1:0] state_q;
    logic [MOORE_W-1:0] state_d;

    // Next-state selection from the current code and the level.
    always_comb begin
        case (state_q)
            MO_WAIT_RISE: state_d = level_i ? MO_EDGE_SEEN : MO_WAIT_RISE;
            MO_EDGE_SEEN: state_d = level_i ? MO_HELD_HIGH : MO_WAIT_RISE;
            MO_HELD_HIGH: state_d = level_i ? MO_HELD_HIGH : MO_WAIT_RISE;
            default:      state_d = MO_WAIT_RISE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MO_WAIT_RISE;
        else        state_q <= state_d;
    end

    // Pulse decode: low bit set and high bit clear.
    always_comb pulse_o = state_q[0] & ~state_q[1];

    assign state_o = state_q;

    // R2: a rise while waiting leads to the edge-seen code.
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MO_WAIT_RISE && level_i) |=> (state_q == MO_EDGE_SEEN));

    // R2: a low level always returns the machine to waiting.
    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !level_i |=> (state_q == MO_WAIT_RISE));

    // R2: the unused code recovers on the next edge.
    p_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MO_UNUSED) |=> (state_q == MO_WAIT_RISE));

    // R7: a pulse never lasts two cycles.
    p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/lvl_pulse_mealy.sv
// Module: lvl_pulse_mealy
// Two-state Mealy rising-edge detector. The state is the previous sample
// of the level, and the pulse combines it with the live level.
// Assumes level_i is synchronous to clk. The pulse is forced low during reset.
module lvl_pulse_mealy
    import lvl_pulse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o,
    output logic state_o
);
    logic state_q;

    // Store the last sampled level, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ME_WAS_LOW;
        else        state_q <= level_i ? ME_WAS_HIGH : ME_WAS_LOW;
    end

    // Pulse while the level is high and the stored sample is still low.
    always_comb pulse_o = rst_n & level_i & (state_q == ME_WAS_LOW);

    assign state_o = state_q;

    // R4: a high level is remembered at the next edge.
    p_track_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> state_q);

    // R4: a low level is remembered at the next edge.
    p_track_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !level_i |=> !state_q);

    // R1: the pulse is never asserted while reset is held.
    always_comb begin
        if (!rst_n) p_rst_quiet_r1: assert (!pulse_o);
    end
endmodule

// File: rtl/lvl_pulse_top.sv
// Module: lvl_pulse_top
// Runs the Moore and Mealy edge detectors on the same level input and
// exposes both pulses and both state vectors.
// Assumes level_in is already synchronised to clk.
module lvl_pulse_top
    import lvl_pulse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_in,
    output logic               moore_pulse,
    output logic               mealy_pulse,
    output logic [MOORE_W-1:0] moore_state,
    output logic               mealy_state
);
    lvl_pulse_moore u_moore (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_in),
        .pulse_o (moore_pulse),
        .state_o (moore_state)
    );

    lvl_pulse_mealy u_mealy (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_in),
        .pulse_o (mealy_pulse),
        .state_o (mealy_state)
    );

    // R6: the Moore pulse follows a Mealy pulse by exactly one cycle.
    p_late_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mealy_pulse |=> moore_pulse);

    // R6: no Moore pulse appears without a Mealy pulse the cycle before.
    p_late_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mealy_pulse |=> !moore_pulse);

    // R3: the Moore pulse and the edge-seen code always coincide.
    p_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        moore_pulse == (moore_state == MO_EDGE_SEEN));

    // R5: the Mealy pulse and the Moore state never disagree about a rise.
    p_mealy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mealy_pulse |-> (moore_state[0] == 1'b0));
endmodule

// File: tb/lvl_pulse_top_bench.sv
// Directed bench for lvl_pulse_top. The reference model keeps the last
// two sampled values of the level input.
module lvl_pulse_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       level_in = 1'b0;
    logic       moore_pulse;
    logic       mealy_pulse;
    logic [1:0] moore_state;
    logic       mealy_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model state: level sampled at the last edge, and the one before.
    logic prev1 = 1'b0;
    logic prev2 = 1'b0;

    // Pulse counters used by the hold and gap scenarios.
    int cnt_mealy = 0;
    int cnt_moore = 0;

    always #10 clk = ~clk;

    lvl_pulse_top u_lvl_pulse_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_in    (level_in),
        .moore_pulse (moore_pulse),
        .mealy_pulse (mealy_pulse),
        .moore_state (moore_state),
        .mealy_state (mealy_state)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, check every output, then advance the model.
    task automatic step(input logic lv, input logic rn, input string req);
        logic e_mealy;
        logic e_moore;
        @(negedge clk);
        level_in = lv;
        rst_n = rn;
        #1;
        e_mealy = rn & lv & ~prev1;
        e_moore = prev1 & ~prev2;
        chk({req, "/R5"}, "mealy_pulse", int'(mealy_pulse), int'(e_mealy));
        chk({req, "/R6"}, "moore_pulse", int'(moore_pulse), int'(e_moore));
        chk({req, "/R2"}, "moore_state", int'(moore_state), int'({prev1 & prev2, prev1}));
        chk({req, "/R4"}, "mealy_state", int'(mealy_state), int'(prev1));
        cnt_mealy += int'(mealy_pulse);
        cnt_moore += int'(moore_pulse);
        if (!rn) begin
            prev2 = 1'b0;
            prev1 = 1'b0;
        end else begin
            prev2 = prev1;
            prev1 = lv;
        end
    endtask

    // R1: reset clears both machines and gates the Mealy pulse.
    task automatic t_reset();
        rst_n = 1'b0;
        level_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "moore_state in reset", int'(moore_state), 0);
        chk("R1", "mealy_state in reset", int'(mealy_state), 0);
        chk("R1", "mealy_pulse in reset", int'(mealy_pulse), 0);
        chk("R1", "moore_pulse in reset", int'(moore_pulse), 0);
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
    endtask

    // R3 and R5: a single short rise, walking 00 -> 01 -> 11 -> 00.
    task automatic t_single_rise();
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
    endtask

    // R7: a long high level gives one pulse per machine.
    task automatic t_hold_high();
        cnt_mealy = 0;
        cnt_moore = 0;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, "R7");
        chk("R7", "mealy pulse count", cnt_mealy, 1);
        chk("R7", "moore pulse count", cnt_moore, 1);
    endtask

    // R8: one-cycle low gaps each yield a fresh pulse.
    task automatic t_short_gap();
        step(1'b0, 1'b1, "R8");
        cnt_mealy = 0;
        cnt_moore = 0;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, "R8");
            step(1'b1, 1'b1, "R8");
            step(1'b0, 1'b1, "R8");
        end
        step(1'b0, 1'b1, "R8");
        chk("R8", "mealy pulse count", cnt_mealy, 4);
        chk("R8", "moore pulse count", cnt_moore, 4);
    endtask

    // R4 and R6: alternating level every cycle, and an irregular pattern.
    task automatic t_toggle();
        logic [15:0] pat = 16'b1011_0010_1110_0101;
        for (int i = 0; i < 12; i++) step(logic'(i % 2), 1'b1, "R6");
        for (int i = 0; i < 16; i++) step(pat[i], 1'b1, "R4");
    endtask

    // R1: reset asserted while the level is high and a pulse is due.
    task automatic t_reset_mid();
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
    endtask

    initial begin
        t_reset();
        t_single_rise();
        t_hold_high();
        t_short_gap();
        t_toggle();
        t_reset_mid();
        step(1'b0, 1'b1, "R2");
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule